// File: doc/BRIEF.md
# Ethernet RMON Statistics Counter Bank

This block keeps per-port frame and byte statistics for one Ethernet port. The MAC issues a one-cycle event for every received frame and every transmitted frame. Each event carries the frame length and a set of flag bits. From these events the bank updates frame counters, byte counters and seven length bins per direction. It also keeps a separate count of received frames longer than a programmable maximum. Every counter wraps modulo its width and never saturates.

Software collects the counts through a one-cycle read port. Every read of a counter also clears that counter. A byte counter is wider than the read word, so it is read in two parts. Reading the low part returns the low bits, clears the counter, and copies the upper bits into a holding register. A later read of the high address returns that holding register. A global clear input zeroes every counter and both holding registers at once.

An event that coincides with a clear is never lost. The counter starts again from the event's own contribution.

A small response state machine orders the read port. It has two states:
- `ST_IDLE`: no response is pending.
- `ST_RESP`: read data is valid.

It has four transitions:
- *accept*: `ST_IDLE` to `ST_RESP` when `rd_en` is high.
- *stream*: `ST_RESP` to `ST_RESP` when `rd_en` is high, which allows back-to-back reads.
- *drain*: `ST_RESP` to `ST_IDLE` when `rd_en` is low.
- *rest*: `ST_IDLE` to `ST_IDLE` when `rd_en` is low.

Top module: `rmon_stat_bank`

## Requirements
- R1: A read with `rd_en` high at a clock edge gives `rd_vld` high in the next cycle, with the counter value from before that edge on `rd_data`. Otherwise `rd_vld` is low and `rd_data` is zero. Word addresses: receive counters at 0–16, transmit counters at 17–28, receive bytes low/high at 32/33, transmit bytes low/high at 34/35. All other addresses (29–31, 36–63) read as zero.
- R2: Frame counters are `FRM_W` bits wide (32 by default). They wrap to zero after their all-ones value.
- R3: Every receive event adds 1 to the receive frame counter (address 0) and adds `rx_len` to the receive byte counter. Every transmit event does the same on transmit frame count (address 17) and transmit bytes.
- R4: Receive flag bits map to counters as follows: bit0 multicast → address 1, bit1 broadcast → 2, bit2 pause → 3, bit3 FCS error → 4, bit4 symbol error → 5, bit5 short → 6, bit6 jabber → 7, bit7 oversize → 8. Transmit flag bits: bit0 multicast → 18, bit1 broadcast → 19, bit2 pause → 20.
- R5: Each frame lands in exactly one length bin. The bins are length ≤64, 65–127, 128–255, 256–511, 512–1023, 1024–1518 and ≥1519. Receive bins sit at addresses 10–16 and transmit bins at 22–28, in that order.
- R6: A received frame with length greater than `max_len` adds 1 to address 9. This does not depend on the oversize flag. The oversize flag alone does not touch address 9.
- R7: The transmit error counter (address 21) adds 1 for a frame with flag bit3 (FCS error) or bit4 (underrun/other error) set.
- R8: A read of a frame counter or of a byte-counter low address clears that counter. A second read returns zero.
- R9: Byte counters are `BYTE_W` bits wide (45 by default).
  - A low read returns bits `RD_W-1:0` and copies the upper bits into a holding register.
  - A high read returns that holding register. It is not affected by later events and does not clear anything.
- R10: An event in the same cycle as a read that clears its counter is counted into the fresh value. The next read returns 1 (or the length, for bytes).
- R11: `clear_all` zeroes every counter and both holding registers. An event in the same cycle counts into the fresh value.
- R12: After reset, every counter and holding register is zero and `rd_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_all | input | 1 | Zero all counters and holding registers |
| max_len | input | LEN_W | Programmed maximum receive frame length |
| rx_vld | input | 1 | Receive frame event |
| rx_len | input | LEN_W | Receive frame length in bytes |
| rx_flag | input | 8 | Receive frame flags (see R4) |
| tx_vld | input | 1 | Transmit frame event |
| tx_len | input | LEN_W | Transmit frame length in bytes |
| tx_flag | input | 5 | Transmit frame flags (see R4, R7) |
| rd_en | input | 1 | Read request |
| rd_addr | input | 6 | Read word address |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | RD_W | Read data |

## Verification
Two functions can fall in the same cycle. The first is a clear, either clear-on-read or `clear_all`. The second is a frame event aimed at the counter being cleared. The bench drives a receive event in the very cycle that reads address 0. It does the same in a cycle with `clear_all` raised. It then reads again and expects exactly one count, with the first read still returning the value from before the clear. Likewise, a low byte-counter read coincides with the latch of the holding register. A frame sent between the low and high reads must not change the high word.

// File: rtl/rmon_stat_pkg.sv
`timescale 1ns/1ps
package rmon_stat_pkg;

    // Word addresses of the frame counters
    localparam int RX_FRAMES   = 0;
    localparam int RX_MCAST    = 1;
    localparam int RX_BCAST    = 2;
    localparam int RX_PAUSE    = 3;
    localparam int RX_FCS      = 4;
    localparam int RX_SYM      = 5;
    localparam int RX_SHORT    = 6;
    localparam int RX_JABBER   = 7;
    localparam int RX_OVERSIZE = 8;
    localparam int RX_MAXLEN   = 9;
    localparam int RX_BIN0     = 10;
    localparam int TX_FRAMES   = 17;
    localparam int TX_MCAST    = 18;
    localparam int TX_BCAST    = 19;
    localparam int TX_PAUSE    = 20;
    localparam int TX_ERR      = 21;
    localparam int TX_BIN0     = 22;
    localparam int NUM_FRM     = 29;
    localparam int BIN_CNT     = 7;

    // Byte counter addresses: low word at BYTE_BASE + 2k, high word follows
    localparam int BYTE_BASE   = 32;
    localparam int NUM_BYTE    = 2;
    localparam int ADDR_W      = 6;

    localparam int RX_FLAG_W   = 8;
    localparam int TX_FLAG_W   = 5;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rd_state_e;

    // Inclusive upper length bound of bin i (last bin is open-ended)
    function automatic int bin_upper(input int i);
        case (i)
            0:       return 64;
            1:       return 127;
            2:       return 255;
            3:       return 511;
            4:       return 1023;
            5:       return 1518;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/stats_len_bin.sv
`timescale 1ns/1ps
module stats_len_bin
    import rmon_stat_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic [LEN_W-1:0]   len,
    output logic [BIN_CNT-1:0] bin_hit
);

    for (genvar i = 0; i < BIN_CNT; i++) begin : g_bin
        if (i == 0) begin : g_first
            localparam int UP = bin_upper(0);
            assign bin_hit[i] = (len <= LEN_W'(UP));
        end else if (i == BIN_CNT - 1) begin : g_last
            localparam int LO = bin_upper(i - 1);
            assign bin_hit[i] = (len > LEN_W'(LO));
        end else begin : g_mid
            localparam int LO = bin_upper(i - 1);
            localparam int UP = bin_upper(i);
            assign bin_hit[i] = (len > LEN_W'(LO)) && (len <= LEN_W'(UP));
        end
    end

endmodule

// File: rtl/stats_cnt.sv
`timescale 1ns/1ps
module stats_cnt #(
    parameter int W     = 32,
    parameter int INC_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc_en,
    input  logic [INC_W-1:0] inc_amt,
    output logic [W-1:0]     q
);

    logic [W-1:0] base;
    logic [W-1:0] step;

    // A clear restarts from zero; an event in the same cycle still counts
    assign base = clr ? '0 : q;
    assign step = inc_en ? W'(inc_amt) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= base + step;
        end
    end

endmodule

// File: rtl/rmon_stat_bank.sv
`timescale 1ns/1ps
module rmon_stat_bank
    import rmon_stat_pkg::*;
#(
    parameter int LEN_W  = 14,
    parameter int FRM_W  = 32,
    parameter int BYTE_W = 45,
    parameter int RD_W   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_all,
    input  logic [LEN_W-1:0]     max_len,
    input  logic                 rx_vld,
    input  logic [LEN_W-1:0]     rx_len,
    input  logic [RX_FLAG_W-1:0] rx_flag,
    input  logic                 tx_vld,
    input  logic [LEN_W-1:0]     tx_len,
    input  logic [TX_FLAG_W-1:0] tx_flag,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic                 rd_vld,
    output logic [RD_W-1:0]      rd_data
);

    localparam int HI_W = BYTE_W - RD_W;

    logic [BIN_CNT-1:0]              rx_bin;
    logic [BIN_CNT-1:0]              tx_bin;
    logic [NUM_FRM-1:0]              frm_hit;
    logic [NUM_FRM-1:0]              frm_clr;
    logic [NUM_FRM-1:0][FRM_W-1:0]   frm_q;
    logic [NUM_BYTE-1:0]             byte_en;
    logic [NUM_BYTE-1:0][LEN_W-1:0]  byte_len;
    logic [NUM_BYTE-1:0]             byte_lo_rd;
    logic [NUM_BYTE-1:0][BYTE_W-1:0] byte_q;
    logic [NUM_BYTE-1:0][HI_W-1:0]   hold_q;
    logic [RD_W-1:0]                 rd_word;
    rd_state_e                       state_q;
    rd_state_e                       state_d;

    // ---------------- length binning ----------------
    stats_len_bin #(.LEN_W(LEN_W)) u_rx_bin (.len(rx_len), .bin_hit(rx_bin));
    stats_len_bin #(.LEN_W(LEN_W)) u_tx_bin (.len(tx_len), .bin_hit(tx_bin));

    // ---------------- event to counter mapping ----------------
    always_comb begin
        frm_hit = '0;
        frm_hit[RX_FRAMES]   = rx_vld;
        frm_hit[RX_MCAST]    = rx_vld & rx_flag[0];
        frm_hit[RX_BCAST]    = rx_vld & rx_flag[1];
        frm_hit[RX_PAUSE]    = rx_vld & rx_flag[2];
        frm_hit[RX_FCS]      = rx_vld & rx_flag[3];
        frm_hit[RX_SYM]      = rx_vld & rx_flag[4];
        frm_hit[RX_SHORT]    = rx_vld & rx_flag[5];
        frm_hit[RX_JABBER]   = rx_vld & rx_flag[6];
        frm_hit[RX_OVERSIZE] = rx_vld & rx_flag[7];
        frm_hit[RX_MAXLEN]   = rx_vld & (rx_len > max_len);
        frm_hit[RX_BIN0 +: BIN_CNT] = rx_vld ? rx_bin : '0;
        frm_hit[TX_FRAMES]   = tx_vld;
        frm_hit[TX_MCAST]    = tx_vld & tx_flag[0];
        frm_hit[TX_BCAST]    = tx_vld & tx_flag[1];
        frm_hit[TX_PAUSE]    = tx_vld & tx_flag[2];
        frm_hit[TX_ERR]      = tx_vld & (tx_flag[3] | tx_flag[4]);
        frm_hit[TX_BIN0 +: BIN_CNT] = tx_vld ? tx_bin : '0;
    end

    assign byte_en  = {tx_vld, rx_vld};
    assign byte_len = {tx_len, rx_len};

    // ---------------- read decode ----------------
    always_comb begin
        frm_clr    = '0;
        byte_lo_rd = '0;
        rd_word    = '0;
        for (int k = 0; k < NUM_FRM; k++) begin
            if (rd_addr == ADDR_W'(k)) begin
                frm_clr[k] = rd_en;
                rd_word    = RD_W'(frm_q[k]);
            end
        end
        for (int k = 0; k < NUM_BYTE; k++) begin
            if (rd_addr == ADDR_W'(BYTE_BASE + 2 * k)) begin
                byte_lo_rd[k] = rd_en;
                rd_word       = byte_q[k][RD_W-1:0];
            end
            if (rd_addr == ADDR_W'(BYTE_BASE + 2 * k + 1)) begin
                rd_word = RD_W'(hold_q[k]);
            end
        end
    end

    // ---------------- counter arrays ----------------
    for (genvar i = 0; i < NUM_FRM; i++) begin : g_frm
        stats_cnt #(.W(FRM_W), .INC_W(1)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clear_all | frm_clr[i]),
            .inc_en  (frm_hit[i]),
            .inc_amt (1'b1),
            .q       (frm_q[i])
        );
    end

    for (genvar i = 0; i < NUM_BYTE; i++) begin : g_byte
        stats_cnt #(.W(BYTE_W), .INC_W(LEN_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clear_all | byte_lo_rd[i]),
            .inc_en  (byte_en[i]),
            .inc_amt (byte_len[i]),
            .q       (byte_q[i])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q[i] <= '0;
            end else if (clear_all) begin
                hold_q[i] <= '0;
            end else if (byte_lo_rd[i]) begin
                hold_q[i] <= byte_q[i][BYTE_W-1:RD_W];
            end
        end
    end

    // ---------------- response state machine ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = rd_en ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_en ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= (state_d == ST_RESP) ? rd_word : '0;
        end
    end

    assign rd_vld = (state_q == ST_RESP);

endmodule

// File: rtl/rmon_stat_bank_chk.sv
`timescale 1ns/1ps
module rmon_stat_bank_chk
    import rmon_stat_pkg::*;
#(
    parameter int LEN_W  = 14,
    parameter int FRM_W  = 32,
    parameter int BYTE_W = 45,
    parameter int RD_W   = 32
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                clear_all,
    input logic                                rx_vld,
    input logic                                tx_vld,
    input logic                                rd_en,
    input logic [ADDR_W-1:0]                   rd_addr,
    input logic                                rd_vld,
    input logic [RD_W-1:0]                     rd_data,
    input logic [NUM_FRM-1:0][FRM_W-1:0]       frm_q,
    input logic [NUM_BYTE-1:0][BYTE_W-1:0]     byte_q,
    input logic [NUM_BYTE-1:0][BYTE_W-RD_W-1:0] hold_q
);

    // R1
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_vld);

    // R1
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_vld && rd_data == '0));

    // R1
    hole_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_W'(30)) |=> rd_data == '0);

    // R2
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && !clear_all && !(rd_en && rd_addr == ADDR_W'(RX_FRAMES))
         && frm_q[RX_FRAMES] == '1) |=> frm_q[RX_FRAMES] == '0);

    // R9
    hold_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_W'(BYTE_BASE) && !clear_all)
        |=> hold_q[0] == $past(byte_q[0][BYTE_W-1:RD_W]));

    // R10
    read_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_W'(RX_FRAMES) && rx_vld && !clear_all)
        |=> frm_q[RX_FRAMES] == FRM_W'(1));

    // R11
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_all && !rx_vld && !tx_vld)
        |=> (frm_q == '0 && byte_q == '0 && hold_q == '0));

endmodule

bind rmon_stat_bank rmon_stat_bank_chk #(
    .LEN_W(LEN_W), .FRM_W(FRM_W), .BYTE_W(BYTE_W), .RD_W(RD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .rx_vld(rx_vld),
    .tx_vld(tx_vld), .rd_en(rd_en), .rd_addr(rd_addr), .rd_vld(rd_vld),
    .rd_data(rd_data), .frm_q(frm_q), .byte_q(byte_q), .hold_q(hold_q)
);

// File: tb/rmon_stat_bank_tb.sv
`timescale 1ns/1ps
module rmon_stat_bank_tb;

    localparam int LEN_W  = 14;
    localparam int FRM_W  = 12;
    localparam int BYTE_W = 28;
    localparam int RD_W   = 16;
    localparam int NFRM   = 29;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              clear_all;
    logic [LEN_W-1:0]  max_len;
    logic              rx_vld;
    logic [LEN_W-1:0]  rx_len;
    logic [7:0]        rx_flag;
    logic              tx_vld;
    logic [LEN_W-1:0]  tx_len;
    logic [4:0]        tx_flag;
    logic              rd_en;
    logic [5:0]        rd_addr;
    logic              rd_vld;
    logic [RD_W-1:0]   rd_data;

    always #2.5 clk = ~clk;

    rmon_stat_bank #(.LEN_W(LEN_W), .FRM_W(FRM_W), .BYTE_W(BYTE_W), .RD_W(RD_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .max_len(max_len),
        .rx_vld(rx_vld), .rx_len(rx_len), .rx_flag(rx_flag),
        .tx_vld(tx_vld), .tx_len(tx_len), .tx_flag(tx_flag),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_vld(rd_vld), .rd_data(rd_data)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model
    longint unsigned mf[NFRM];
    longint unsigned mb[2];
    longint unsigned mh[2];
    longint unsigned frm_mask  = (64'd1 << FRM_W) - 1;
    longint unsigned byte_mask = (64'd1 << BYTE_W) - 1;
    longint unsigned rd_mask   = (64'd1 << RD_W) - 1;
    int              cur_max   = 1518;

    longint unsigned exp_q[$];
    string           tag_q[$];

    task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int bin_of(input int len);
        if (len <= 64)        return 0;
        else if (len <= 127)  return 1;
        else if (len <= 255)  return 2;
        else if (len <= 511)  return 3;
        else if (len <= 1023) return 4;
        else if (len <= 1518) return 5;
        else                  return 6;
    endfunction

    function automatic longint unsigned model_read(input int a);
        if (a < NFRM)  return mf[a];
        if (a == 32)   return mb[0] & rd_mask;
        if (a == 33)   return mh[0];
        if (a == 34)   return mb[1] & rd_mask;
        if (a == 35)   return mh[1];
        return 0;
    endfunction

    function automatic void bump(input int idx);
        mf[idx] = (mf[idx] + 1) & frm_mask;
    endfunction

    // Driver: one clock cycle of stimulus, expected read result to scoreboard
    task automatic cyc(input bit rv, input int rl, input bit [7:0] rf,
                       input bit tv, input int tl, input bit [4:0] tf,
                       input bit re, input int ra, input bit ca, input string tag);
        @(negedge clk);
        rx_vld = rv; rx_len = LEN_W'(rl); rx_flag = rf;
        tx_vld = tv; tx_len = LEN_W'(tl); tx_flag = tf;
        rd_en = re; rd_addr = 6'(ra); clear_all = ca;
        max_len = LEN_W'(cur_max);
        if (re) begin
            exp_q.push_back(model_read(ra));
            tag_q.push_back(tag);
        end
        if (re && ra < NFRM) mf[ra] = 0;
        for (int k = 0; k < 2; k++) begin
            if (re && ra == 32 + 2 * k) begin
                mh[k] = mb[k] >> RD_W;
                mb[k] = 0;
            end
        end
        if (ca) begin
            for (int k = 0; k < NFRM; k++) mf[k] = 0;
            for (int k = 0; k < 2; k++) begin mb[k] = 0; mh[k] = 0; end
        end
        if (rv) begin
            bump(0);
            for (int b = 0; b < 8; b++) if (rf[b]) bump(1 + b);
            if (rl > cur_max) bump(9);
            bump(10 + bin_of(rl));
            mb[0] = (mb[0] + longint'(rl)) & byte_mask;
        end
        if (tv) begin
            bump(17);
            for (int b = 0; b < 3; b++) if (tf[b]) bump(18 + b);
            if (tf[3] || tf[4]) bump(21);
            bump(22 + bin_of(tl));
            mb[1] = (mb[1] + longint'(tl)) & byte_mask;
        end
    endtask

    task automatic rx(input int len, input bit [7:0] f);
        cyc(1, len, f, 0, 0, 0, 0, 0, 0, "");
    endtask
    task automatic tx(input int len, input bit [4:0] f);
        cyc(0, 0, 0, 1, len, f, 0, 0, 0, "");
    endtask
    task automatic rd(input int a, input string tag);
        cyc(0, 0, 0, 0, 0, 0, 1, a, 0, tag);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    endtask

    // Monitor: pop and compare each response
    always @(negedge clk) begin
        if (rst_n && rd_vld) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected response", 1, 0);
            end else begin
                check(tag_q.pop_front(), longint'(rd_data), exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        check("watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        for (int k = 0; k < NFRM; k++) mf[k] = 0;
        for (int k = 0; k < 2; k++) begin mb[k] = 0; mh[k] = 0; end
        rst_n = 1'b0; clear_all = 0; max_len = LEN_W'(cur_max);
        rx_vld = 0; rx_len = '0; rx_flag = '0;
        tx_vld = 0; tx_len = '0; tx_flag = '0;
        rd_en = 0; rd_addr = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 rd_vld after reset", longint'(rd_vld), 0);
        check("R12 rd_data after reset", longint'(rd_data), 0);
        rd(0, "R12 rx frames zero");
        rd(21, "R12 tx err zero");
        rd(32, "R12 rx bytes zero");
        rd(35, "R12 tx hold zero");

        // R3 R4 R5 basic receive
        rx(64, 8'b0000_0001);
        rx(100, 8'b0000_0010);
        rd(0, "R3 rx frames");
        rd(1, "R4 rx mcast");
        rd(2, "R4 rx bcast");
        rd(10, "R5 rx bin64");
        rd(11, "R5 rx bin65_127");
        rd(32, "R3 rx bytes lo");
        // R4 remaining receive flags
        rx(300, 8'b1111_1100);
        for (int a = 3; a <= 8; a++) rd(a, "R4 rx flag counter");

        // R5 bin boundaries both directions
        begin
            int lens[14] = '{63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519, 9000};
            for (int i = 0; i < 14; i++) begin
                rx(lens[i], 8'h00);
                tx(lens[i], 5'h00);
            end
        end
        for (int a = 10; a <= 16; a++) rd(a, "R5 rx bin");
        for (int a = 22; a <= 28; a++) rd(a, "R5 tx bin");
        rd(17, "R3 tx frames");
        rd(34, "R3 tx bytes lo");

        // R6 max length error apart from oversize
        cur_max = 1000;
        rx(1200, 8'h00);
        rx(800, 8'h80);
        rx(1000, 8'h00);
        rd(9, "R6 maxlen error");
        rd(8, "R6 oversize flag count");
        cur_max = 1518;

        // R7 tx error sources, R4 tx flags
        tx(64, 5'b01000);
        tx(64, 5'b10000);
        tx(64, 5'b00111);
        rd(21, "R7 tx err");
        rd(18, "R4 tx mcast");
        rd(19, "R4 tx bcast");
        rd(20, "R4 tx pause");

        // R8 clear on read
        rx(64, 8'h00);
        rd(0, "R8 first read");
        rd(0, "R8 second read zero");
        rd(30, "R1 hole address");
        rd(40, "R1 hole address");

        // R10 event in the same cycle as its read
        rx(64, 8'h00);
        rx(64, 8'h00);
        cyc(1, 70, 8'h00, 0, 0, 0, 1, 0, 0, "R10 read before collide");
        rd(0, "R10 fresh count");
        cyc(1, 90, 8'h00, 0, 0, 0, 1, 32, 0, "R10 bytes before collide");
        rd(32, "R10 fresh bytes");

        // R11 clear_all with concurrent event
        rx(64, 8'h01);
        tx(200, 5'h01);
        cyc(1, 64, 8'h00, 0, 0, 0, 1, 1, 1, "R11 read during clear");
        rd(0, "R11 event counted after clear");
        rd(1, "R11 mcast cleared");
        rd(18, "R11 tx mcast cleared");
        rd(34, "R11 tx bytes cleared");
        rd(32, "R11 rx bytes after clear");

        // R9 byte counter split
        rd(32, "R9 drain");
        for (int i = 0; i < 5; i++) rx(16000, 8'h00);
        rd(32, "R9 low word");
        rx(100, 8'h00);
        rd(33, "R9 high word");
        rd(33, "R9 high word repeat");
        rd(32, "R9 low after high");

        // R2 frame counter wrap
        rd(17, "R2 drain");
        for (int i = 0; i < (1 << FRM_W) + 1; i++) tx(64, 5'h00);
        rd(17, "R2 wrapped tx frames");

        idle(4);
        check("R1 all responses seen", exp_q.size(), 0);
        finish_run();
    end

endmodule